// File: doc/BRIEF.md
# Clause 45 management-bus slave

This block is the slave end of a two-wire management bus that carries Clause 45 frames. It runs from a fast system clock and watches the slow bus clock (MDC) and the shared data line (MDIO) through synchronisers. It finds the 32-bit run of ones that opens each frame and then reads the 32-bit command body. The body holds, most significant bit first: a 2-bit start field `00`, a 2-bit opcode, a 5-bit port address, a 5-bit device address, two turnaround bits and a 16-bit payload. The block compares the two addresses with the values on its configuration pins. A frame that does not match is ignored.

A matching address frame loads the payload into an internal 16-bit register pointer. A write frame hands the pointer and the payload to the host with a one-cycle strobe. Read and post-read-increment frames ask the host for a data word as soon as the header matches. The host must return that word before the first turnaround bit ends. The block then takes over the line through an output enable and shifts the word out. After a post-read-increment frame that it sent, it steps the pointer. Two event pulses tell the host about progress: one when the address matches, and one when a frame it accepted ends. Device address values such as 00001 (PMA/PMD) or 00011 (PCS) are just compared; the block gives no meaning to them.

Top module: `mdio_c45_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones are sampled on MDC rising edges right before the start field. A run of 31 ones followed by a frame leaves every output unchanged, and a longer run is accepted.
- R2: A start field other than `00` (for example `01`) sends the block back to preamble search. The frame that follows gives no events, no write and no change of `regAddr`.
- R3: After reset `regAddr` is 0. A matching frame with opcode `00` loads `regAddr` with its 16-bit payload, received most significant bit first. `regAddr` changes only in the cycle where `frameEvt` is high.
- R4: A matching frame with opcode `01` raises `wrStrobe` for exactly one clock, together with `frameEvt`. During that clock `wrData` equals the payload and `regAddr` equals the current pointer. No other opcode raises `wrStrobe`.
- R5: When the received port address (body bits 4..8) or device address (body bits 9..13) differs from `cfgPortAddr` or `cfgDevAddr`, the frame gives no `matchEvt`, no `frameEvt`, no `rdReq` and no write. The block does not drive MDIO and `regAddr` is unchanged.
- R6: When the last device-address bit of a matching header has been sampled, `matchEvt` pulses for one clock, before the payload arrives. For opcodes `11` (read) and `10` (post-read-increment), `rdReq` pulses in the same clock.
- R7: Each accepted frame ends with exactly one one-clock `frameEvt`, after the last payload bit has been sampled.
- R8: After reset `mdioOe` is 0. In a read frame the block leaves MDIO undriven during the first turnaround bit, and drives 0 with `mdioOe` high during the second.
- R9: In a read frame the 16 bits of the word latched from `rdData` are driven most significant bit first, one per MDC period, after the turnaround. Each bit changes just after a rising MDC edge. After the last bit `mdioOe` returns to 0.
- R10: After a post-read-increment frame (opcode `10`) that sent its data, `regAddr` is one more than before, and it wraps from 0xFFFF to 0x0000.
- R11: If `rdValid` has not arrived between `rdReq` and the MDC rising edge that ends the first turnaround bit, the block does not drive MDIO for that frame. A post-read-increment frame then leaves `regAddr` unchanged, and `frameEvt` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than MDC |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| mdc | input | 1 | Management bus clock from the station |
| mdioIn | input | 1 | Received level of the shared data line |
| mdioOut | output | 1 | Level to drive onto the data line |
| mdioOe | output | 1 | Drive enable for the data line; low leaves it undriven |
| cfgPortAddr | input | 5 | Port address this slave answers to |
| cfgDevAddr | input | 5 | Device address this slave answers to |
| regAddr | output | 16 | Current register pointer |
| wrStrobe | output | 1 | One-clock write request to the host |
| wrData | output | 16 | Payload of the last write frame |
| rdReq | output | 1 | One-clock request for a read word |
| rdData | input | 16 | Read word from the host |
| rdValid | input | 1 | Host marks `rdData` valid |
| matchEvt | output | 1 | Pulse: port and device address matched |
| frameEvt | output | 1 | Pulse: accepted frame complete |

## Verification
The assertions assume that MDC stays in each phase for many system clocks, and that MDIO holds steady around each rising MDC edge. Under those conditions each bus bit is seen exactly once after synchronisation. They also assume the configuration pins do not change while a frame is in progress. The bench drives MDC with eight system clocks per phase and changes MDIO only while MDC is low. It keeps the configuration constant, and returns read words a few clocks after `rdReq`, well inside the turnaround deadline, except in the one case that tests the deadline on purpose.

// File: rtl/mdio_c45_pkg.sv
`timescale 1ns/1ps
package mdio_c45_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_PRIA  = 2'b10,
    OP_READ  = 2'b11
  } mdioOp_e;

  // strobes from control to datapath, all valid for one clk
  typedef struct packed {
    logic hdrClr;     // new frame body starts
    logic addrLoad;   // load pointer from payload
    logic addrInc;    // step pointer
    logic wrPulse;    // issue host write
    logic rdOpen;     // window in which rdValid is accepted
    logic txLoad;     // start driving: turnaround zero
    logic txStep;     // launch next data bit
    logic txRelease;  // stop driving
  } dpStrobe_t;

endpackage

// File: rtl/mdio_c45_sync.sv
`timescale 1ns/1ps
module mdio_c45_sync #(
  parameter int STAGES = 2,
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/mdio_c45_dp.sv
`timescale 1ns/1ps
module mdio_c45_dp
  import mdio_c45_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PORT_W = 5,
  parameter int DEV_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdc,
  input  logic              mdioIn,
  input  logic [PORT_W-1:0] cfgPort,
  input  logic [DEV_W-1:0]  cfgDev,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdValid,
  input  dpStrobe_t         strb,
  output logic              mdcRise,
  output logic              bitIn,
  output logic [1:0]        hdrOp,
  output logic              hdrMatch,
  output logic              rdHave,
  output logic [DATA_W-1:0] regAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrStrobe,
  output logic              mdioOut,
  output logic              mdioOe
);

  localparam int ADR_W = PORT_W + DEV_W;
  localparam int HDR_W = 2 + ADR_W;

  logic [1:0]        syncQ;
  logic              mdcS;
  logic              mdcPrev;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] payload;
  logic [HDR_W-1:0]  hdrNext;
  logic [DATA_W-1:0] rdHold;
  logic [DATA_W-1:0] txReg;

  mdio_c45_sync #(
    .STAGES (SYNC_STAGES),
    .W      (2),
    .RST_VAL(2'b10)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({mdioIn, mdc}),
    .q   (syncQ)
  );

  assign mdcS    = syncQ[0];
  assign bitIn   = syncQ[1];
  assign mdcRise = mdcS & ~mdcPrev;

  // view of the shift register including the bit arriving now
  assign payload  = {rxShift[DATA_W-2:0], bitIn};
  assign hdrNext  = payload[HDR_W-1:0];
  assign hdrOp    = hdrNext[HDR_W-1 -: 2];
  assign hdrMatch = (hdrNext[ADR_W-1:DEV_W] == cfgPort) &&
                    (hdrNext[DEV_W-1:0] == cfgDev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdcPrev <= 1'b0;
      rxShift <= '0;
    end else begin
      mdcPrev <= mdcS;
      if (mdcRise) rxShift <= payload;
    end
  end

  // register pointer and host write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAddr  <= '0;
      wrData   <= '0;
      wrStrobe <= 1'b0;
    end else begin
      wrStrobe <= strb.wrPulse;
      if (strb.wrPulse) wrData <= payload;
      if (strb.addrLoad)     regAddr <= payload;
      else if (strb.addrInc) regAddr <= regAddr + 1'b1;
    end
  end

  // read word capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHave <= 1'b0;
      rdHold <= '0;
    end else if (strb.hdrClr) begin
      rdHave <= 1'b0;
    end else if (strb.rdOpen && rdValid) begin
      rdHave <= 1'b1;
      rdHold <= rdData;
    end
  end

  // line driver, launched just after the synchronised rising edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdioOe  <= 1'b0;
      mdioOut <= 1'b0;
      txReg   <= '0;
    end else if (strb.txLoad) begin
      mdioOe  <= 1'b1;
      mdioOut <= 1'b0;
      txReg   <= rdHold;
    end else if (strb.txRelease) begin
      mdioOe  <= 1'b0;
      mdioOut <= 1'b0;
    end else if (strb.txStep) begin
      mdioOut <= txReg[DATA_W-1];
      txReg   <= {txReg[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/mdio_c45_ctrl.sv
`timescale 1ns/1ps
module mdio_c45_ctrl
  import mdio_c45_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HDR_LEN = 12,
  parameter int PRE_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mdcRise,
  input  logic       bitIn,
  input  logic [1:0] hdrOp,
  input  logic       hdrMatch,
  input  logic       rdHave,
  output dpStrobe_t  strb,
  output logic       matchEvt,
  output logic       frameEvt,
  output logic       rdReq
);

  localparam int TA_LEN   = 2;
  localparam int SKIP_LEN = TA_LEN + DATA_W;
  localparam int MAX_CNT  = (PRE_LEN > SKIP_LEN) ? PRE_LEN : SKIP_LEN;
  localparam int CNT_W    = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] C_PRE  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] C_HDR  = CNT_W'(HDR_LEN - 1);
  localparam logic [CNT_W-1:0] C_DATA = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] C_SKIP = CNT_W'(SKIP_LEN - 1);

  typedef enum logic [2:0] {
    S_PRE, S_ST2, S_HDR, S_TA, S_DATA, S_SKIP
  } state_e;

  state_e     state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  mdioOp_e    opReg, nOp;
  logic       txOn, nTxOn;
  logic       matchHit, frameDone, readAsk;

  always_comb begin
    nState    = state;
    nCnt      = cnt;
    nOp       = opReg;
    nTxOn     = txOn;
    strb      = '0;
    matchHit  = 1'b0;
    frameDone = 1'b0;
    readAsk   = 1'b0;
    strb.rdOpen = (state == S_TA) && (cnt == '0) && opReg[1];
    if (mdcRise) begin
      unique case (state)
        S_PRE: begin
          if (bitIn) begin
            if (cnt != C_PRE) nCnt = cnt + 1'b1;
          end else if (cnt == C_PRE) begin
            nState = S_ST2;
            nCnt   = '0;
          end else begin
            nCnt = '0;
          end
        end
        S_ST2: begin
          nCnt = '0;
          if (!bitIn) begin
            nState      = S_HDR;
            nTxOn       = 1'b0;
            strb.hdrClr = 1'b1;
          end else begin
            nState = S_PRE;
          end
        end
        S_HDR: begin
          if (cnt == C_HDR) begin
            nCnt = '0;
            if (hdrMatch) begin
              nState   = S_TA;
              nOp      = mdioOp_e'(hdrOp);
              matchHit = 1'b1;
              readAsk  = hdrOp[1];
            end else begin
              nState = S_SKIP;
            end
          end else begin
            nCnt = cnt + 1'b1;
          end
        end
        S_TA: begin
          if (cnt == '0) begin
            nCnt = cnt + 1'b1;
            if (opReg[1] && rdHave) begin
              strb.txLoad = 1'b1;
              nTxOn       = 1'b1;
            end
          end else begin
            nCnt   = '0;
            nState = S_DATA;
            strb.txStep = txOn;
          end
        end
        S_DATA: begin
          if (cnt == C_DATA) begin
            nCnt      = '0;
            nState    = S_PRE;
            frameDone = 1'b1;
            strb.txRelease = txOn;
            unique case (opReg)
              OP_ADDR:  strb.addrLoad = 1'b1;
              OP_WRITE: strb.wrPulse  = 1'b1;
              OP_PRIA:  strb.addrInc  = txOn;
              OP_READ:  ;
            endcase
          end else begin
            nCnt = cnt + 1'b1;
            strb.txStep = txOn;
          end
        end
        S_SKIP: begin
          if (cnt == C_SKIP) begin
            nCnt   = '0;
            nState = S_PRE;
          end else begin
            nCnt = cnt + 1'b1;
          end
        end
        default: begin
          nCnt   = '0;
          nState = S_PRE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_PRE;
      cnt      <= '0;
      opReg    <= OP_ADDR;
      txOn     <= 1'b0;
      matchEvt <= 1'b0;
      frameEvt <= 1'b0;
      rdReq    <= 1'b0;
    end else begin
      state    <= nState;
      cnt      <= nCnt;
      opReg    <= nOp;
      txOn     <= nTxOn;
      matchEvt <= matchHit;
      frameEvt <= frameDone;
      rdReq    <= readAsk;
    end
  end

endmodule

// File: rtl/mdio_c45_slave.sv
`timescale 1ns/1ps
module mdio_c45_slave
  import mdio_c45_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PORT_W = 5,
  parameter int DEV_W = 5,
  parameter int PRE_LEN = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdc,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic [PORT_W-1:0] cfgPortAddr,
  input  logic [DEV_W-1:0]  cfgDevAddr,
  output logic [DATA_W-1:0] regAddr,
  output logic              wrStrobe,
  output logic [DATA_W-1:0] wrData,
  output logic              rdReq,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdValid,
  output logic              matchEvt,
  output logic              frameEvt
);

  localparam int HDR_LEN = 2 + PORT_W + DEV_W;

  dpStrobe_t  strb;
  logic       mdcRise;
  logic       bitIn;
  logic [1:0] hdrOp;
  logic       hdrMatch;
  logic       rdHave;

  mdio_c45_ctrl #(
    .DATA_W (DATA_W),
    .HDR_LEN(HDR_LEN),
    .PRE_LEN(PRE_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .mdcRise (mdcRise),
    .bitIn   (bitIn),
    .hdrOp   (hdrOp),
    .hdrMatch(hdrMatch),
    .rdHave  (rdHave),
    .strb    (strb),
    .matchEvt(matchEvt),
    .frameEvt(frameEvt),
    .rdReq   (rdReq)
  );

  mdio_c45_dp #(
    .DATA_W     (DATA_W),
    .PORT_W     (PORT_W),
    .DEV_W      (DEV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .mdc     (mdc),
    .mdioIn  (mdioIn),
    .cfgPort (cfgPortAddr),
    .cfgDev  (cfgDevAddr),
    .rdData  (rdData),
    .rdValid (rdValid),
    .strb    (strb),
    .mdcRise (mdcRise),
    .bitIn   (bitIn),
    .hdrOp   (hdrOp),
    .hdrMatch(hdrMatch),
    .rdHave  (rdHave),
    .regAddr (regAddr),
    .wrData  (wrData),
    .wrStrobe(wrStrobe),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe)
  );

endmodule

// File: rtl/mdio_c45_chk.sv
`timescale 1ns/1ps
module mdio_c45_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic [DATA_W-1:0] regAddr,
  input logic              wrStrobe,
  input logic              rdReq,
  input logic              matchEvt,
  input logic              frameEvt
);

  logic readOpen;
  logic matchOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readOpen  <= 1'b0;
      matchOpen <= 1'b0;
    end else begin
      if (rdReq)         readOpen <= 1'b1;
      else if (frameEvt) readOpen <= 1'b0;
      if (matchEvt)      matchOpen <= 1'b1;
      else if (frameEvt) matchOpen <= 1'b0;
    end
  end

  AST_PTR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regAddr) |-> frameEvt); // R3
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R4
  AST_WR_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> frameEvt); // R4
  AST_DRIVE_ONLY_ASKED: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> readOpen); // R5
  AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    matchEvt |=> !matchEvt); // R6
  AST_RDREQ_WITH_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> matchEvt); // R6
  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameEvt |=> !frameEvt); // R7
  AST_FRAME_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    frameEvt |-> matchOpen); // R7
  AST_DRIVE_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut); // R8

endmodule

bind mdio_c45_slave mdio_c45_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mdioOut (mdioOut),
  .mdioOe  (mdioOe),
  .regAddr (regAddr),
  .wrStrobe(wrStrobe),
  .rdReq   (rdReq),
  .matchEvt(matchEvt),
  .frameEvt(frameEvt)
);

// File: tb/mdio_c45_slave_tb.sv
`timescale 1ns/1ps
module mdio_c45_slave_tb;

  localparam logic [4:0] MY_PORT = 5'b10110;
  localparam logic [4:0] MY_DEV  = 5'b00011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mdc = 1'b0;
  logic        mdioIn = 1'b1;
  logic        mdioOut, mdioOe;
  logic [15:0] regAddr, wrData, rdData;
  logic        wrStrobe, rdReq, rdValid, matchEvt, frameEvt;

  int checks = 0;
  int failures = 0;
  int matchCnt = 0, frameCnt = 0, wrCnt = 0, rdReqCnt = 0;
  logic [15:0] lastWrAddr = '0, lastWrData = '0;
  logic [15:0] expPtr = '0;
  bit hostOn = 1'b1;
  logic smpOe [32];
  logic smpOut [32];

  always #4 clk = ~clk;

  mdio_c45_slave u_dut (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe),
    .cfgPortAddr(MY_PORT), .cfgDevAddr(MY_DEV),
    .regAddr(regAddr), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdReq(rdReq), .rdData(rdData), .rdValid(rdValid),
    .matchEvt(matchEvt), .frameEvt(frameEvt)
  );

  function automatic logic [15:0] rdFunc(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // event monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (matchEvt) matchCnt++;
      if (frameEvt) frameCnt++;
      if (rdReq) rdReqCnt++;
      if (wrStrobe) begin
        wrCnt++;
        lastWrAddr = regAddr;
        lastWrData = wrData;
      end
    end
  end

  // host read responder
  initial begin
    rdData = '0;
    rdValid = 1'b0;
    forever begin
      @(negedge clk);
      if (rdReq && hostOn) begin
        logic [15:0] snap;
        snap = regAddr;
        repeat (3) @(negedge clk);
        rdData = rdFunc(snap);
        rdValid = 1'b1;
        @(negedge clk);
        rdValid = 1'b0;
      end
    end
  end

  // one bus bit; called at a negedge of clk with mdc low
  task automatic bitCycle(input logic b, input int idx);
    mdioIn = b;
    repeat (7) @(negedge clk);
    if (idx >= 0) begin
      smpOe[idx] = mdioOe;
      smpOut[idx] = mdioOut;
    end
    @(negedge clk);
    mdc = 1'b1;
    repeat (8) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic sendFrame(input int preLen, input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] port, input logic [4:0] dev,
                           input logic [15:0] pay);
    logic [31:0] body;
    body = {st, op, port, dev, 2'b10, pay};
    for (int i = 0; i < 32; i++) begin
      smpOe[i] = 1'b0;
      smpOut[i] = 1'b0;
    end
    for (int i = 0; i < preLen; i++) bitCycle(1'b1, -1);
    for (int i = 0; i < 32; i++) begin
      if (op[1] && i >= 14) bitCycle(1'b1, i);
      else bitCycle(body[31-i], i);
    end
    mdioIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int oeSum();
    int s = 0;
    for (int i = 0; i < 32; i++) if (smpOe[i]) s++;
    return s;
  endfunction

  // mk: 0 match, 1 wrong port, 2 wrong device
  task automatic runFrame(input logic [1:0] op, input int mk, input logic [15:0] pay,
                          input int preLen);
    int m0, f0, w0, q0;
    logic [4:0] port, dev;
    logic [15:0] word, expWord;
    m0 = matchCnt; f0 = frameCnt; w0 = wrCnt; q0 = rdReqCnt;
    port = (mk == 1) ? (MY_PORT ^ 5'b00100) : MY_PORT;
    dev  = (mk == 2) ? (MY_DEV ^ 5'b10000) : MY_DEV;
    sendFrame(preLen, 2'b00, op, port, dev, pay);
    if (mk != 0) begin
      check("R5 matchEvt count", matchCnt, m0);
      check("R5 frameEvt count", frameCnt, f0);
      check("R5 write count", wrCnt, w0);
      check("R5 rdReq count", rdReqCnt, q0);
      check("R5 drive samples", oeSum(), 0);
      check("R5 regAddr", regAddr, expPtr);
      return;
    end
    check("R6 matchEvt count", matchCnt, m0 + 1);
    check("R7 frameEvt count", frameCnt, f0 + 1);
    check("R6 rdReq count", rdReqCnt, q0 + (op[1] ? 1 : 0));
    if (op != 2'b01) check("R4 no write", wrCnt, w0);
    case (op)
      2'b00: begin
        expPtr = pay;
        check("R3 address load", regAddr, expPtr);
      end
      2'b01: begin
        check("R4 write count", wrCnt, w0 + 1);
        check("R4 write data", lastWrData, pay);
        check("R4 write address", lastWrAddr, expPtr);
        check("R4 regAddr kept", regAddr, expPtr);
      end
      default: begin
        if (hostOn) begin
          check("R8 turnaround one undriven", smpOe[14], 1'b0);
          check("R8 turnaround two driven zero", {smpOe[15], smpOut[15]}, 2'b10);
          expWord = rdFunc(expPtr);
          word = '0;
          for (int k = 0; k < 16; k++) begin
            word = {word[14:0], smpOut[16+k]};
            if (!smpOe[16+k]) check("R9 data bit driven", k, 99);
          end
          check("R9 read word", word, expWord);
          check("R9 released after frame", mdioOe, 1'b0);
          if (op == 2'b10) begin
            expPtr = expPtr + 16'd1;
            check("R10 pointer step", regAddr, expPtr);
          end else begin
            check("R9 pointer kept on read", regAddr, expPtr);
          end
        end else begin
          check("R11 no drive when word late", oeSum(), 0);
          check("R11 pointer kept", regAddr, expPtr);
        end
      end
    endcase
  endtask

  initial begin
    int f0;
    logic [15:0] keep;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 reset regAddr", regAddr, 16'h0000);
    check("R8 reset mdioOe", mdioOe, 1'b0);
    check("R4 reset wrStrobe", wrStrobe, 1'b0);

    // directed
    runFrame(2'b00, 0, 16'h1234, 32);
    runFrame(2'b01, 0, 16'hBEEF, 32);
    runFrame(2'b11, 0, 16'h0000, 32);
    runFrame(2'b10, 0, 16'h0000, 32);
    runFrame(2'b00, 0, 16'hFFFF, 32);
    runFrame(2'b10, 0, 16'h0000, 32);   // R10 wrap to 0
    check("R10 wrap to zero", regAddr, 16'h0000);
    runFrame(2'b00, 1, 16'h7777, 32);
    runFrame(2'b11, 2, 16'h0000, 32);

    // R1 short preamble
    f0 = frameCnt; keep = regAddr;
    sendFrame(31, 2'b00, 2'b00, MY_PORT, MY_DEV, 16'hA0A0);
    check("R1 short preamble frames", frameCnt, f0);
    check("R1 short preamble regAddr", regAddr, keep);
    runFrame(2'b00, 0, 16'h0C0C, 40);
    check("R1 long preamble accepted", regAddr, 16'h0C0C);

    // R2 bad start
    f0 = frameCnt;
    sendFrame(32, 2'b01, 2'b00, MY_PORT, MY_DEV, 16'h5555);
    check("R2 bad start frames", frameCnt, f0);
    check("R2 bad start regAddr", regAddr, expPtr);

    // R11 late read word
    hostOn = 1'b0;
    runFrame(2'b10, 0, 16'h0000, 32);
    runFrame(2'b11, 0, 16'h0000, 32);
    hostOn = 1'b1;

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [1:0] op;
      int mk;
      op = 2'($urandom % 4);
      mk = (($urandom % 4) == 0) ? int'(1 + ($urandom % 2)) : 0;
      runFrame(op, mk, 16'($urandom), 32 + int'($urandom % 4));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule